// File: doc/BRIEF.md
# Reset sequence manager

This block merges three reset requests into one fixed reset sequence. The requests are an external active-low reset pin, a low-voltage detect flag and a watchdog timeout. Every sequence runs three phases in order: an active phase whose length depends on what started it, a stabilization delay, and a two-cycle reset vector fetch. While the sequence runs, the block holds the core in reset and pulls the shared open-drain reset pin low. During the fetch it presents the two vector byte addresses in turn.

The external pin passes through a two-flop synchronizer and a pulse-width filter. A low level must last a minimum number of clock cycles before it counts as a request. When an internal source fires, an internal pulse generator pulls the pin low for a fixed number of cycles. When the pin is pressed from outside, the active phase lasts until the outside releases it. A configuration bit chooses between a short and a long stabilization delay. A request that arrives at any point in the sequence starts the sequence again from its active phase. A sticky cause register records which sources have fired since software last cleared it.

The block runs from an always-on clock that keeps running while the CPU clock is halted, so a request that arrives in halt mode is still seen. The system reset `rst_n` only initialises the block itself.

Top module: `rst_seq_mgr`

## Requirements
- R1: Each of the three sources starts a sequence: a single-cycle high on `wdg_req`, a single-cycle high on `lvd_req`, or a recognised external low on `pin_in`.
- R2: An internal request sampled at clock edge E0 gives an active phase of ACT_CYC (default 4) cycles. During that phase `pin_drive_low` is 1 and `core_rst_n` is 0.
- R3: The delay phase lasts DLY_SHORT (256) cycles when `long_delay_sel` is 0 and DLY_LONG (4096) cycles when it is 1. Throughout the delay, `pin_drive_low` is 1 and `core_rst_n` is 0.
- R4: The fetch phase lasts exactly 2 cycles with `fetch_valid` 1 and `core_rst_n` 1. `fetch_addr` is 16'hFFFE in the first cycle and 16'hFFFF in the second. For an internal request sampled at edge E0, the first fetch cycle follows edge E0+ACT_CYC+delay.
- R5: An external low is recognised only if the pin is sampled low on at least FILT_CYC (default 4) consecutive clock edges. A low that lasts FILT_CYC-1 edges has no effect.
- R6: For an external reset first sampled low at edge F0 and held for L edges, the block does not drive the pin during the active phase. The active phase ends once the synchronized pin reads high again, so the delay starts at edge F0+L+2.
- R7: A request arriving during the delay or fetch phase restarts the sequence from a new active phase and reloads the delay counter. Any fetch cycle that had not yet occurred is dropped.
- R8: A low on the pin caused by the block's own drive, including the two synchronizer cycles after the drive is released, never starts another sequence.
- R9: `reset_cause` has bit 0 for external, bit 1 for low-voltage and bit 2 for watchdog. Each bit is set when its source fires and stays set through later sequences. A high on `status_clr` clears all bits on the next edge.
- R10: After `rst_n` is released, `core_rst_n` is 1, `pin_drive_low` is 0, `fetch_valid` is 0 and `reset_cause` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Synchronous active-low reset of the block itself |
| pin_in | input | 1 | Level read back from the open-drain reset pin, active low |
| lvd_req | input | 1 | Low-voltage detect request, active high, synchronous |
| wdg_req | input | 1 | Watchdog timeout request, active high, synchronous |
| long_delay_sel | input | 1 | Static configuration: 0 selects the short delay, 1 the long delay |
| status_clr | input | 1 | Software write that clears the cause register |
| pin_drive_low | output | 1 | Enable of the open-drain pull-down on the reset pin |
| core_rst_n | output | 1 | Core reset, active low |
| fetch_valid | output | 1 | Reset vector fetch in progress |
| fetch_addr | output | 16 | Vector byte address during the fetch |
| reset_cause | output | 3 | Sticky record of the sources that have fired |

## Verification
For an internal request sampled at edge E0, the two fetch cycles are due after edges E0+ACT_CYC+delay and one edge later. For an external low first sampled at F0 and held for L edges, they are due after edges F0+L+2+delay and one edge later. The cause bits are due one edge after the request. The driver computes these edge numbers from the bench's own edge counter when it applies the stimulus and queues them with the expected address. The monitor samples on the falling clock edge, compares every fetch cycle against the head of the queue, and reports a fetch that nothing expected as a spurious reset. Restart cases queue only the fetch cycles that must survive the restart.

// File: rtl/rsm_pkg.sv
// Package: shared types and constants of the reset sequence manager.
// Assumes: nothing beyond IEEE 1800-2017.
package rsm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_DELAY  = 2'd2,
        ST_FETCH  = 2'd3
    } rsm_state_e;

    // Bit positions in the cause register
    localparam int CAUSE_EXT = 0;
    localparam int CAUSE_LVD = 1;
    localparam int CAUSE_WDG = 2;
    localparam int CAUSE_W   = 3;

endpackage

// File: rtl/rsm_pin_filter.sv
// Module: rsm_pin_filter
// Synchronizes the reset pin readback and qualifies a low level as an
// external request once it has been seen for FILT_CYC consecutive edges.
// Readback made low by the block's own drive is masked, including the
// two cycles the synchronizer still shows low after the drive stops.
// Assumes: clk is always on; self_drive comes from registered state.
module rsm_pin_filter #(
    parameter int FILT_CYC = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    input  logic self_drive,
    output logic pin_low_s,
    output logic ext_fire
);
    localparam int FW = $clog2(FILT_CYC + 1);
    localparam logic [FW-1:0] FIRE_AT = FW'(FILT_CYC - 1);
    localparam logic [FW-1:0] FULL    = FW'(FILT_CYC);

    logic          sync1, sync2;
    logic [1:0]    drv_hist;
    logic [FW-1:0] low_cnt;
    logic          qual_low;

    // Two-flop synchronizer on the pin readback
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync1 <= 1'b1;
            sync2 <= 1'b1;
        end else begin
            sync1 <= pin_in;
            sync2 <= sync1;
        end
    end

    // History of the own drive, covering the synchronizer latency
    always_ff @(posedge clk) begin
        if (!rst_n) drv_hist <= 2'b00;
        else        drv_hist <= {drv_hist[0], self_drive};
    end

    assign pin_low_s = ~sync2;
    assign qual_low  = pin_low_s & ~self_drive & ~(|drv_hist);

    // Consecutive-low counter, saturating at FILT_CYC
    always_ff @(posedge clk) begin
        if (!rst_n)              low_cnt <= '0;
        else if (!qual_low)      low_cnt <= '0;
        else if (low_cnt != FULL) low_cnt <= low_cnt + 1'b1;
    end

    assign ext_fire = qual_low && (low_cnt == FIRE_AT);

    // One recognition per low span
    p_single_fire_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fire |=> !ext_fire);

    // A recognised request never follows directly on the block's own drive
    p_no_self_trigger_r8: assert property (@(posedge clk) disable iff (!rst_n)
        self_drive |=> !ext_fire);

endmodule

// File: rtl/rsm_sequencer.sv
// Module: rsm_sequencer
// Phase controller: active phase (internal pulse or external hold),
// stabilization delay of selectable length, then two vector fetch cycles.
// Any request restarts from the active phase.
// Assumes: int_req is synchronous to clk; long_sel is static.
module rsm_sequencer
    import rsm_pkg::*;
#(
    parameter int          ACT_CYC   = 4,
    parameter int          DLY_SHORT = 256,
    parameter int          DLY_LONG  = 4096,
    parameter int          AW        = 16,
    parameter logic [15:0] VEC_BASE  = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ext_fire,
    input  logic          int_req,
    input  logic          pin_low_s,
    input  logic          long_sel,
    output logic          pin_drive_low,
    output logic          core_rst_n,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr
);
    localparam int ACW = $clog2(ACT_CYC + 1);
    localparam int DW  = $clog2(DLY_LONG + 1);
    localparam logic [ACW-1:0] ACT_LOAD = ACW'(ACT_CYC - 1);
    localparam logic [DW-1:0]  LOAD_S   = DW'(DLY_SHORT - 1);
    localparam logic [DW-1:0]  LOAD_L   = DW'(DLY_LONG - 1);
    localparam logic [AW-1:0]  VEC_LO   = AW'(VEC_BASE);

    rsm_state_e     state;
    logic           from_ext;
    logic [ACW-1:0] act_cnt;
    logic [DW-1:0]  dly_cnt;
    logic           beat;
    logic           any_req;
    logic [DW-1:0]  dly_load;

    assign any_req  = ext_fire | int_req;
    assign dly_load = long_sel ? LOAD_L : LOAD_S;

    // Phase state machine with counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            from_ext <= 1'b0;
            act_cnt  <= '0;
            dly_cnt  <= '0;
            beat     <= 1'b0;
        end else if (any_req) begin
            state    <= ST_ACTIVE;
            from_ext <= ext_fire & ~int_req;
            act_cnt  <= ACT_LOAD;
        end else begin
            case (state)
                ST_ACTIVE: begin
                    if (from_ext) begin
                        if (!pin_low_s) begin
                            state   <= ST_DELAY;
                            dly_cnt <= dly_load;
                        end
                    end else if (act_cnt == '0) begin
                        state   <= ST_DELAY;
                        dly_cnt <= dly_load;
                    end else begin
                        act_cnt <= act_cnt - 1'b1;
                    end
                end
                ST_DELAY: begin
                    if (dly_cnt == '0) begin
                        state <= ST_FETCH;
                        beat  <= 1'b0;
                    end else begin
                        dly_cnt <= dly_cnt - 1'b1;
                    end
                end
                ST_FETCH: begin
                    if (!beat) beat  <= 1'b1;
                    else       state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Output decode from registered state
    always_comb begin
        pin_drive_low = (state == ST_DELAY) || (state == ST_ACTIVE && !from_ext);
        core_rst_n    = !(state == ST_ACTIVE || state == ST_DELAY);
        fetch_valid   = (state == ST_FETCH);
        fetch_addr    = {VEC_LO[AW-1:1], beat};
    end

    // Entering the delay loads the length chosen by the option bit
    p_delay_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DELAY) |-> dly_cnt == dly_load);

    // The delay counter steps down by one each cycle
    p_delay_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DELAY && dly_cnt != '0 && !any_req) |=>
        (state == ST_DELAY && dly_cnt == $past(dly_cnt) - 1'b1));

    // The core is held while the pin is driven
    p_core_held_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pin_drive_low |-> !core_rst_n);

    // The first fetch cycle is followed by the second vector address
    p_fetch_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && fetch_addr == VEC_LO && !any_req) |=>
        (fetch_valid && fetch_addr == (VEC_LO | AW'(1))));

    // A request always restarts into the active phase
    p_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        any_req |=> (state == ST_ACTIVE && !fetch_valid));

endmodule

// File: rtl/rsm_cause_reg.sv
// Module: rsm_cause_reg
// Sticky record of reset sources. A new event wins over a clear in the
// same cycle. The reset sequence does not clear it; only rst_n and
// status_clr do.
// Assumes: source strobes are synchronous to clk.
module rsm_cause_reg
    import rsm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ext_evt,
    input  logic               lvd_evt,
    input  logic               wdg_evt,
    input  logic               status_clr,
    output logic [CAUSE_W-1:0] cause
);
    logic [CAUSE_W-1:0] set_vec;

    // Gather the per-source strobes into bit positions
    always_comb begin
        set_vec            = '0;
        set_vec[CAUSE_EXT] = ext_evt;
        set_vec[CAUSE_LVD] = lvd_evt;
        set_vec[CAUSE_WDG] = wdg_evt;
    end

    // Sticky accumulate with software clear
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (status_clr ? '0 : cause) | set_vec;
    end

    // Bits stay set until a clear
    p_cause_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !status_clr |=> ((cause & $past(cause)) == $past(cause)));

endmodule

// File: rtl/rst_seq_mgr.sv
// Module: rst_seq_mgr (top)
// Merges external pin, low-voltage and watchdog requests into one
// reset sequence, drives the open-drain pin and the core reset, and
// presents the vector fetch addresses.
// Assumes: clk is an always-on clock; lvd_req and wdg_req are synchronous.
module rst_seq_mgr
    import rsm_pkg::*;
#(
    parameter int          FILT_CYC  = 4,
    parameter int          ACT_CYC   = 4,
    parameter int          DLY_SHORT = 256,
    parameter int          DLY_LONG  = 4096,
    parameter int          AW        = 16,
    parameter logic [15:0] VEC_BASE  = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pin_in,
    input  logic          lvd_req,
    input  logic          wdg_req,
    input  logic          long_delay_sel,
    input  logic          status_clr,
    output logic          pin_drive_low,
    output logic          core_rst_n,
    output logic          fetch_valid,
    output logic [AW-1:0] fetch_addr,
    output logic [CAUSE_W-1:0] reset_cause
);
    logic pin_low_s;
    logic ext_fire;

    rsm_pin_filter #(.FILT_CYC(FILT_CYC)) u_filter (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_in     (pin_in),
        .self_drive (pin_drive_low),
        .pin_low_s  (pin_low_s),
        .ext_fire   (ext_fire)
    );

    rsm_sequencer #(
        .ACT_CYC   (ACT_CYC),
        .DLY_SHORT (DLY_SHORT),
        .DLY_LONG  (DLY_LONG),
        .AW        (AW),
        .VEC_BASE  (VEC_BASE)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .ext_fire      (ext_fire),
        .int_req       (lvd_req | wdg_req),
        .pin_low_s     (pin_low_s),
        .long_sel      (long_delay_sel),
        .pin_drive_low (pin_drive_low),
        .core_rst_n    (core_rst_n),
        .fetch_valid   (fetch_valid),
        .fetch_addr    (fetch_addr)
    );

    rsm_cause_reg u_cause (
        .clk        (clk),
        .rst_n      (rst_n),
        .ext_evt    (ext_fire),
        .lvd_evt    (lvd_req),
        .wdg_evt    (wdg_req),
        .status_clr (status_clr),
        .cause      (reset_cause)
    );

    // A source strobe shows in the cause register one edge later
    p_cause_capture_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wdg_req || lvd_req) |=> (reset_cause[CAUSE_WDG] || reset_cause[CAUSE_LVD]));

endmodule

// File: tb/rst_seq_mgr_tb.sv
module rst_seq_mgr_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FILT = 4;
    localparam int ACT  = 4;
    localparam int DS   = 256;
    localparam int DL   = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_pull = 1'b0;
    logic lvd_req = 1'b0, wdg_req = 1'b0, long_sel = 1'b0, status_clr = 1'b0;
    logic pin_in, pin_drive_low, core_rst_n, fetch_valid;
    logic [15:0] fetch_addr;
    logic [2:0]  reset_cause;

    int unsigned cyc = 0;
    int vectors = 0;
    int miscompares = 0;
    bit finished = 0;

    typedef struct packed {
        logic [31:0] at;
        logic [15:0] addr;
    } exp_t;
    exp_t expq[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign pin_in = ~(pin_drive_low | ext_pull);

    rst_seq_mgr u_dut (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .lvd_req(lvd_req),
        .wdg_req(wdg_req), .long_delay_sel(long_sel), .status_clr(status_clr),
        .pin_drive_low(pin_drive_low), .core_rst_n(core_rst_n),
        .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .reset_cause(reset_cause)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Driver side of the scoreboard: queue both fetch cycles of a sequence
    task automatic push_seq(input int unsigned first_at);
        expq.push_back('{at: first_at,     addr: 16'hFFFE});
        expq.push_back('{at: first_at + 1, addr: 16'hFFFF});
    endtask

    // Internal request; returns the edge that samples it
    task automatic pulse_int(input bit is_wdg, output int unsigned e0);
        e0 = cyc + 1;
        if (is_wdg) wdg_req = 1'b1; else lvd_req = 1'b1;
        @(negedge clk);
        wdg_req = 1'b0;
        lvd_req = 1'b0;
    endtask

    // External low held for len edges; returns first low edge
    task automatic pull_ext(input int len, output int unsigned f0);
        f0 = cyc + 1;
        ext_pull = 1'b1;
        repeat (len) @(posedge clk);
        @(negedge clk);
        ext_pull = 1'b0;
    endtask

    task automatic wait_drained();
        while (expq.size() != 0) @(negedge clk);
        repeat (20) @(negedge clk);
    endtask

    task automatic clear_cause();
        status_clr = 1'b1;
        @(negedge clk);
        status_clr = 1'b0;
    endtask

    // Monitor side of the scoreboard
    always @(negedge clk) begin
        if (rst_n && fetch_valid) begin
            if (expq.size() == 0) begin
                vectors++;
                miscompares++;
                $display("FAIL R8 unexpected fetch: actual addr %0h expected none (cycle %0d)",
                         fetch_addr, cyc);
            end else begin
                exp_t e;
                e = expq.pop_front();
                check("R4 R7 fetch cycle", cyc, e.at);
                check("R4 fetch address", {16'h0, fetch_addr}, {16'h0, e.addr});
                check("R4 core released in fetch", {31'h0, core_rst_n}, 32'd1);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        int unsigned e0, f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 core_rst_n", {31'h0, core_rst_n}, 32'd1);
        check("R10 pin_drive_low", {31'h0, pin_drive_low}, 32'd0);
        check("R10 fetch_valid", {31'h0, fetch_valid}, 32'd0);
        check("R10 reset_cause", {29'h0, reset_cause}, 32'd0);

        // R1 R2 R3 watchdog, short delay
        pulse_int(1'b1, e0);
        push_seq(e0 + ACT + DS);
        check("R9 cause after watchdog", {29'h0, reset_cause}, 32'h4);
        check("R2 drive in active", {31'h0, pin_drive_low}, 32'd1);
        check("R2 core held in active", {31'h0, core_rst_n}, 32'd0);
        repeat (ACT + 100) @(negedge clk);
        check("R3 drive in delay", {31'h0, pin_drive_low}, 32'd1);
        check("R3 core held in delay", {31'h0, core_rst_n}, 32'd0);
        wait_drained();
        // R8 own readback did not start another sequence
        check("R8 idle after own drive", {31'h0, pin_drive_low}, 32'd0);
        check("R8 core free after own drive", {31'h0, core_rst_n}, 32'd1);
        check("R9 cause kept after sequence", {29'h0, reset_cause}, 32'h4);
        clear_cause();
        check("R9 cause cleared", {29'h0, reset_cause}, 32'd0);

        // R1 R3 low-voltage, long delay
        long_sel = 1'b1;
        pulse_int(1'b0, e0);
        push_seq(e0 + ACT + DL);
        check("R9 cause after low-voltage", {29'h0, reset_cause}, 32'h2);
        repeat (ACT + 3000) @(negedge clk);
        check("R3 drive late in long delay", {31'h0, pin_drive_low}, 32'd1);
        wait_drained();
        long_sel = 1'b0;
        clear_cause();

        // R1 R5 R6 external pulse at exactly the minimum width
        pull_ext(FILT, f0);
        push_seq(f0 + FILT + 2 + DS);
        wait_drained();
        check("R9 cause after external", {29'h0, reset_cause}, 32'h1);
        clear_cause();

        // R6 long external hold
        pull_ext(FILT + 20, f0);
        push_seq(f0 + FILT + 20 + 2 + DS);
        wait_drained();
        clear_cause();

        // R5 glitch one cycle short is rejected
        pull_ext(FILT - 1, f0);
        repeat (30) @(negedge clk);
        check("R5 short glitch no core reset", {31'h0, core_rst_n}, 32'd1);
        check("R5 short glitch no drive", {31'h0, pin_drive_low}, 32'd0);
        check("R5 short glitch no cause", {29'h0, reset_cause}, 32'd0);

        // R7 restart during delay
        pulse_int(1'b1, e0);
        repeat (100) @(negedge clk);
        pulse_int(1'b0, e0);
        push_seq(e0 + ACT + DS);
        wait_drained();
        check("R9 cause accumulates", {29'h0, reset_cause}, 32'h6);

        // R7 restart during fetch: second cycle must be dropped
        pulse_int(1'b1, e0);
        expq.push_back('{at: e0 + ACT + DS, addr: 16'hFFFE});
        while (cyc != e0 + ACT + DS) @(negedge clk);
        lvd_req = 1'b1;
        push_seq(cyc + 1 + ACT + DS);
        @(negedge clk);
        lvd_req = 1'b0;
        wait_drained();

        check("R4 scoreboard empty", expq.size(), 32'd0);
        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule